// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer with Wait Insertion

This block steps a processor through one bus cycle at a time. Each cycle passes through an address phase (T1), a command phase (T2), a data-hold phase (T3), zero or more wait phases (TW) and a closing phase (T4). The number of wait phases is set by a READY input that is already synchronized to the clock. READY is looked at only on the last clock of T3 and on the last clock of each TW. A wait phase lengthens T3 and always comes between T3 and T4. It never comes between T2 and T3.

A one-clock request strobe starts a cycle, and a direction flag given with it selects read or write. The block drives an address-valid strobe, a write-data enable, a read-capture strobe and a cycle-done pulse, all decoded from its state. A request that arrives while a cycle is running is held, one deep, and its cycle starts in the clock right after T4. The held request takes priority over a new one that arrives in T4.

Top module: `bus_seq`

## Requirements
- R1: While reset is asserted and in the first clock after it, `state_oh` equals 6'b000001 (bit 0 idle) and `addr_valid`, `wr_data_en`, `rd_capture` and `done` are low. At every moment exactly one bit of `state_oh` is set. The bit positions are 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4.
- R2: When `req` is high at a clock edge in idle, the next clock is T1. T1 then lasts exactly one clock and is followed by T2. T2 lasts exactly one clock and is followed by T3.
- R3: If `ready` is high at the edge that ends T3, T4 follows, so a cycle with no waits lasts four clocks. If `ready` is low at that edge, TW follows.
- R4: If `ready` is low at the edge that ends a TW, another TW follows. If it is high, T4 follows. Any number of TW clocks may be inserted.
- R5: The value of `ready` in idle, T1, T2 and T4 has no effect on the sequence.
- R6: `addr_valid` is high in T1 and in no other state.
- R7: `wr_data_en` is high in T3, in each TW and in T4 of a cycle whose `req_wr` was 1 when it was requested. It is low at all other times.
- R8: `rd_capture` is high only in T4 of a cycle whose `req_wr` was 0.
- R9: `done` is high for exactly the T4 clock of every cycle.
- R10: After T4 the next state is T1 if a request is held or `req` is high at that edge. Otherwise the next state is idle. A request raised in T1, T2, T3 or TW is held, together with its direction, and starts the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Cycle request strobe |
| req_wr | input | 1 | Direction given with req: 1 write, 0 read |
| ready | input | 1 | Synchronized ready; low requests a wait |
| state_oh | output | 6 | One-hot state: bit0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4 |
| addr_valid | output | 1 | Address valid strobe (T1) |
| wr_data_en | output | 1 | Write data drive enable |
| rd_capture | output | 1 | Read data capture strobe |
| done | output | 1 | Cycle-complete pulse |

## Verification
The block has no size parameters, so the bench builds it as it stands and sweeps its whole behaviour space instead. It runs every combination of direction and wait count from 0 to 5. For each of these it places a second request in every clock of the first cycle, and also runs the case with no second request. This covers the held-request path, the direct T4-to-T1 path and the return to idle. In T1, T2 and T4 the bench drives READY both high and low, to show that these values are ignored there.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int NUM_ST = 6;
  localparam int ST_W   = $clog2(NUM_ST);

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;

  // Successor of the current phase; rdy matters only at T3/TW sampling points.
  function automatic bus_st_e next_st(bus_st_e cur, logic start, logic rdy);
    bus_st_e n;
    case (cur)
      ST_IDLE: n = start ? ST_T1 : ST_IDLE;
      ST_T1:   n = ST_T2;
      ST_T2:   n = ST_T3;
      ST_T3,
      ST_TW:   n = rdy ? ST_T4 : ST_TW;
      ST_T4:   n = start ? ST_T1 : ST_IDLE;
      default: n = ST_IDLE;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    req_wr,
  input  logic    ready,
  output bus_st_e st,
  output logic    cur_wr
);
  logic    pend, pend_wr;
  bus_st_e nxt;

  // Named events for the checks below
  logic busy, sample_pt, start, hold_req;
  assign busy      = (st == ST_T1) || (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
  assign sample_pt = (st == ST_T3) || (st == ST_TW);
  assign start     = ((st == ST_IDLE) && req) || ((st == ST_T4) && (req || pend));
  assign hold_req  = busy && req && !pend;
  assign nxt       = next_st(st, start, ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pend    <= 1'b0;
      pend_wr <= 1'b0;
      cur_wr  <= 1'b0;
    end else begin
      st <= nxt;
      if (start) begin
        cur_wr <= pend ? pend_wr : req_wr;
        pend   <= 1'b0;
      end else if (hold_req) begin
        pend    <= 1'b1;
        pend_wr <= req_wr;
      end
    end
  end

  AST_T1_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T1) |=> (st == ST_T2)); // R2
  AST_T2_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T2) |=> (st == ST_T3)); // R2
  AST_READY_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && ready) |=> (st == ST_T4)); // R3
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && !ready) |=> (st == ST_TW)); // R4
  AST_HELD_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_T4) && pend) |=> (st == ST_T1)); // R10
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && req) |=> (st == ST_T1)); // R2
endmodule

// File: rtl/bus_seq_decode.sv
module bus_seq_decode
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_st_e           st,
  input  logic              cur_wr,
  output logic [NUM_ST-1:0] state_oh,
  output logic              addr_valid,
  output logic              wr_data_en,
  output logic              rd_capture,
  output logic              done
);
  logic [ST_W-1:0] st_bits;
  logic            data_phase;
  assign st_bits = st;

  for (genvar i = 0; i < NUM_ST; i++) begin : g_oh
    assign state_oh[i] = (st_bits == ST_W'(i));
  end

  assign data_phase = state_oh[ST_T3] | state_oh[ST_TW] | state_oh[ST_T4];
  assign addr_valid = state_oh[ST_T1];
  assign wr_data_en = cur_wr & data_phase;
  assign rd_capture = ~cur_wr & state_oh[ST_T4];
  assign done       = state_oh[ST_T4];

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1); // R1
  AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_capture && wr_data_en)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_en && !done) |=> wr_data_en); // R7
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic              ready,
  output logic [NUM_ST-1:0] state_oh,
  output logic              addr_valid,
  output logic              wr_data_en,
  output logic              rd_capture,
  output logic              done
);
  bus_st_e st;
  logic    cur_wr;

  bus_seq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .req_wr (req_wr),
    .ready  (ready),
    .st     (st),
    .cur_wr (cur_wr)
  );

  bus_seq_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .cur_wr     (cur_wr),
    .state_oh   (state_oh),
    .addr_valid (addr_valid),
    .wr_data_en (wr_data_en),
    .rd_capture (rd_capture),
    .done       (done)
  );
endmodule

// File: tb/bus_seq_test.sv
module bus_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, req_wr = 1'b0, ready = 1'b0;
  logic [5:0] state_oh;
  logic       addr_valid, wr_data_en, rd_capture, done;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  bus_seq uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Check all outputs for a phase index (0 idle,1 T1,2 T2,3 T3,4 TW,5 T4)
  task automatic chk_phase(input int ph, input bit wr);
    string st_tag;
    st_tag = (ph == 4) ? "R4 state" : (ph == 5) ? "R3 state" : "R2 state";
    chk(st_tag, state_oh, 1 << ph);
    chk("R6 addr_valid", addr_valid, ph == 1);
    chk("R7 wr_data_en", wr_data_en, wr && ph >= 3);
    chk("R8 rd_capture", rd_capture, !wr && ph == 5);
    chk("R9 done", done, ph == 5);
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  // One cycle with nw waits; second request injected at clock j (0 = none)
  task automatic run(input bit wr, input int nw, input int j, input bit wr2);
    int last;
    bit noise;
    last  = 4 + nw;
    noise = nw[0];
    req = 1'b1; req_wr = wr; ready = ~noise;  // R5: ready in idle ignored
    tick();
    for (int k = 1; k <= last; k++) begin
      int ph;
      ph = (k <= 3) ? k : (k == last) ? 5 : 4;
      chk_phase(ph, wr);
      req    = (k == j);
      req_wr = wr2;
      if (k >= 3 && k < last) ready = (k == last - 1);
      else ready = noise;  // R5: T1/T2/T4 values must not matter
      tick();
    end
    req = 1'b0;
    if (j > 0) begin
      chk("R10 chained start", state_oh, 6'b000010);
      for (int k = 1; k <= 4; k++) begin
        chk_phase(k == 4 ? 5 : k, wr2);
        ready = (k == 3) ? 1'b1 : ~noise;
        tick();
      end
    end
    chk("R10 return idle", state_oh, 6'b000001);
    ready = 1'b1;
    tick();
    chk("R10 idle hold", state_oh, 6'b000001);
  endtask

  initial begin
    tick();
    chk("R1 reset state", state_oh, 6'b000001);
    chk("R1 reset strobes", {addr_valid, wr_data_en, rd_capture, done}, 0);
    #5 rst_n = 1'b1;
    tick();
    chk("R1 post-reset state", state_oh, 6'b000001);
    chk("R1 post-reset strobes", {addr_valid, wr_data_en, rd_capture, done}, 0);
    for (int w = 0; w < 2; w++)
      for (int nw = 0; nw <= 5; nw++)
        for (int j = 0; j <= 4 + nw; j++)
          run(w[0], nw, j, ~w[0]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule